// File: doc/BRIEF.md
# Command Mailbox Responder

This block is the device side of a small command mailbox that sits behind a byte-wide register bus with single-cycle read and write strobes. Software places a 16-bit argument in two outgoing bytes, keeps a fourth outgoing byte at zero, and then writes an 8-bit operation code into the third outgoing byte. That last write starts execution. The responder decodes the code and updates its configuration store, which holds the relay output latch, a high period, a low period and a burst count for each pulse-width channel, and a channel enable mask. It then posts a 16-bit reply in two incoming bytes and copies the operation code into a third incoming byte. Software polls that byte until it matches the code it sent.

Because completion is shown by a matching code and not by a busy flag, two identical commands in a row cannot be told apart. Software therefore issues the clear operation between them, which zeroes the echo byte. The fourth incoming byte is separate from the command path. It shows the 8 isolated inputs after a two-stage synchronizer, refreshed at a fixed sample interval.

Top module: `mbox_responder`

## Requirements
- R1: After a synchronous active-low reset, `relay_out`, `bus_rdata`, every outgoing and incoming mailbox byte, and every stored configuration value are zero.
- R2: Outgoing bytes sit at offsets 0x0C (argument low), 0x0D (argument high), 0x0E (operation code) and 0x0F (reserved). All four read back what was written. A read returns its byte on `bus_rdata` from the clock edge that samples `bus_rd`, and holds it until the next read. Reads at unmapped offsets return 0x00. Writes to the incoming offsets 0x1C to 0x1F have no effect.
- R3: A write to 0x0E runs the command at the next clock edge, using the argument and reserved byte held just before that edge. A read strobed two cycles after the write returns the new reply at 0x1C (low) and 0x1D (high) and the echoed code at 0x1E. A read strobed one cycle after the write still returns the previous values.
- R4: Code 0x01 loads `relay_out` from the argument low byte and replies {0x00, new state}. Code 0x02 replies {0x00, `relay_out`} and changes nothing. `relay_out` changes only through code 0x01.
- R5: Code 0x00 sets the echo byte to 0x00 and the reply to 0x0000. A following command with the code that was in effect before the clear then shows as newly completed.
- R6: For channel c (0 to NPWM-1), code 0x10+2c stores the high period, code 0x11+2c stores the low period and code 0x14+c stores the burst count. Each stores the 16-bit argument and replies with it. Code 0x1F stores the argument's low NPWM bits as the enable mask and replies with the mask zero-extended.
- R7: Code 0x07 treats the argument low byte as an operation code. It replies with the value that code last stored: the relay state for 0x01 or 0x02, and the stored value for the codes in R6. Any other code gives 0x0000. The echo byte becomes 0x07.
- R8: An unlisted code, or any code while the reserved byte 0x0F is nonzero, leaves the reply bytes, the echo byte, `relay_out` and the configuration store unchanged.
- R9: Offset 0x1F returns `iso_in` after a two-flop synchronizer. It is refreshed once every SAMPLE_DIV cycles by a counter that starts at zero on reset, so the first refresh happens at the SAMPLE_DIV-th edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| iso_in | input | 8 | Asynchronous isolated inputs |
| relay_out | output | 8 | Relay output latch |

## Verification
The hardest state to reach from the ports is a repeat of the code that is already shown in the echo byte. From outside, such a repeat looks like nothing happened, so a clear has to be placed in between to prove that the repeat really ran. The stimulus issues the read-back code twice in a row, then a clear, then the same code again. It also strobes a read one cycle after a command write, so the bench sees the stale echo on one cycle and the fresh echo on the next. A second case that is hard to reach is a nonzero reserved byte, which has to block a relay load while every visible byte stays unchanged.

// File: rtl/mbox_pkg.sv
// Package: operation codes, register offsets and code helpers that are
// shared by the mailbox responder modules. Assumes at most two
// pulse-width channels, so the period and burst-count codes never overlap.
package mbox_pkg;
    localparam logic [7:0] OP_CLEAR   = 8'h00;
    localparam logic [7:0] OP_SET_OUT = 8'h01;
    localparam logic [7:0] OP_GET_OUT = 8'h02;
    localparam logic [7:0] OP_QUERY   = 8'h07;
    localparam logic [7:0] OP_PW_ENA  = 8'h1F;

    localparam int OUT_OFS = 12;   // first outgoing byte
    localparam int IN_OFS  = 28;   // first incoming byte

    // Code that stores the high period of a channel.
    function automatic logic [7:0] op_high(input int ch);
        return 8'(8'h10 + 2 * ch);
    endfunction

    // Code that stores the low period of a channel.
    function automatic logic [7:0] op_low(input int ch);
        return 8'(8'h11 + 2 * ch);
    endfunction

    // Code that stores the burst count of a channel.
    function automatic logic [7:0] op_burst(input int ch);
        return 8'(8'h14 + ch);
    endfunction
endpackage

// File: rtl/mbox_hostregs.sv
// Outgoing mailbox bytes. Holds the argument, the code and the reserved
// byte written by the host. A write to the code byte raises cmd_go for
// exactly the following cycle. Assumes at most one bus strobe per cycle.
module mbox_hostregs
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [15:0]       arg,
    output logic [7:0]        code,
    output logic [7:0]        spare,
    output logic              go
);
    localparam logic [ADDR_W-1:0] A_LO    = ADDR_W'(OUT_OFS);
    localparam logic [ADDR_W-1:0] A_HI    = ADDR_W'(OUT_OFS + 1);
    localparam logic [ADDR_W-1:0] A_CODE  = ADDR_W'(OUT_OFS + 2);
    localparam logic [ADDR_W-1:0] A_SPARE = ADDR_W'(OUT_OFS + 3);

    // Capture host writes and flag a new command for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg   <= '0;
            code  <= '0;
            spare <= '0;
            go    <= 1'b0;
        end else begin
            go <= wr && (addr == A_CODE);
            if (wr) begin
                if (addr == A_LO)    arg[7:0]  <= wdata;
                if (addr == A_HI)    arg[15:8] <= wdata;
                if (addr == A_CODE)  code      <= wdata;
                if (addr == A_SPARE) spare     <= wdata;
            end
        end
    end
endmodule

// File: rtl/mbox_dispatch.sv
// Command dispatcher. On cmd_go it decodes the code, updates the relay
// latch and the per-channel configuration, and posts the reply and echo.
// Assumes NPWM is 1 or 2. Unknown codes, or a nonzero reserved byte,
// leave all state unchanged.
module mbox_dispatch
    import mbox_pkg::*;
#(
    parameter int NPWM = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic [7:0]  code,
    input  logic [15:0] arg,
    input  logic [7:0]  spare,
    output logic        known,
    output logic [7:0]  relay,
    output logic [7:0]  echo,
    output logic [15:0] reply
);
    logic [NPWM-1:0][15:0] high_v, low_v, burst_v;
    logic [NPWM-1:0]       hit_high, hit_low, hit_burst;
    logic [NPWM-1:0]       ena_q;
    logic [15:0]           next_reply;
    logic [15:0]           look_val;
    logic                  accept;

    assign accept = go && known;

    // Per-channel storage for the two periods and the burst count.
    for (genvar ch = 0; ch < NPWM; ch++) begin : g_chan
        logic [15:0] high_r, low_r, burst_r;
        assign hit_high[ch]  = (code == op_high(ch));
        assign hit_low[ch]   = (code == op_low(ch));
        assign hit_burst[ch] = (code == op_burst(ch));
        assign high_v[ch]    = high_r;
        assign low_v[ch]     = low_r;
        assign burst_v[ch]   = burst_r;

        // Store the argument when this channel's code is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                high_r  <= '0;
                low_r   <= '0;
                burst_r <= '0;
            end else if (accept) begin
                if (hit_high[ch])  high_r  <= arg;
                if (hit_low[ch])   low_r   <= arg;
                if (hit_burst[ch]) burst_r <= arg;
            end
        end
    end

    // Look up the value last stored by the code named in the argument.
    always_comb begin
        look_val = '0;
        if (arg[7:0] == OP_SET_OUT || arg[7:0] == OP_GET_OUT)
            look_val = {8'h00, relay};
        if (arg[7:0] == OP_PW_ENA)
            look_val = 16'(ena_q);
        for (int ch = 0; ch < NPWM; ch++) begin
            if (arg[7:0] == op_high(ch))  look_val = high_v[ch];
            if (arg[7:0] == op_low(ch))   look_val = low_v[ch];
            if (arg[7:0] == op_burst(ch)) look_val = burst_v[ch];
        end
    end

    // Decide whether the code is valid and what the reply is.
    always_comb begin
        known      = 1'b1;
        next_reply = '0;
        case (code)
            OP_CLEAR:   next_reply = '0;
            OP_SET_OUT: next_reply = {8'h00, arg[7:0]};
            OP_GET_OUT: next_reply = {8'h00, relay};
            OP_QUERY:   next_reply = look_val;
            OP_PW_ENA:  next_reply = 16'(arg[NPWM-1:0]);
            default: begin
                known = |{hit_high, hit_low, hit_burst};
                next_reply = arg;
            end
        endcase
        if (spare != 8'h00) known = 1'b0;
    end

    // Commit the accepted command: latches, reply and echo.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            relay <= '0;
            ena_q <= '0;
            echo  <= '0;
            reply <= '0;
        end else if (accept) begin
            echo  <= code;
            reply <= next_reply;
            if (code == OP_SET_OUT) relay <= arg[7:0];
            if (code == OP_PW_ENA)  ena_q <= arg[NPWM-1:0];
        end
    end
endmodule

// File: rtl/mbox_insample.sv
// Input sampler. Synchronizes the asynchronous isolated inputs through
// two flops and loads them into the status byte once every DIV cycles.
// Assumes DIV >= 2.
module mbox_insample #(
    parameter int DIV = 12500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] pins,
    output logic [7:0] sampled,
    output logic       tick
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [7:0]    sync1, sync2;
    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    // Synchronize the pins, count the interval and refresh on its wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1   <= '0;
            sync2   <= '0;
            cnt     <= '0;
            sampled <= '0;
        end else begin
            sync1 <= pins;
            sync2 <= sync1;
            if (tick) begin
                cnt     <= '0;
                sampled <= sync2;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mbox_responder.sv
// Top of the command mailbox responder. Joins the outgoing registers, the
// dispatcher and the input sampler, and returns the addressed byte on a
// registered read port. Assumes single-cycle strobes, one per cycle.
module mbox_responder
    import mbox_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int NPWM       = 2,
    parameter int SAMPLE_DIV = 12500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        iso_in,
    output logic [7:0]        relay_out
);
    localparam logic [ADDR_W-1:0] A_OUT0 = ADDR_W'(OUT_OFS);
    localparam logic [ADDR_W-1:0] A_OUT1 = ADDR_W'(OUT_OFS + 1);
    localparam logic [ADDR_W-1:0] A_OUT2 = ADDR_W'(OUT_OFS + 2);
    localparam logic [ADDR_W-1:0] A_OUT3 = ADDR_W'(OUT_OFS + 3);
    localparam logic [ADDR_W-1:0] A_IN0  = ADDR_W'(IN_OFS);
    localparam logic [ADDR_W-1:0] A_IN1  = ADDR_W'(IN_OFS + 1);
    localparam logic [ADDR_W-1:0] A_IN2  = ADDR_W'(IN_OFS + 2);
    localparam logic [ADDR_W-1:0] A_IN3  = ADDR_W'(IN_OFS + 3);

    logic [15:0] cmd_arg;
    logic [7:0]  cmd_code, cmd_spare;
    logic        cmd_go, cmd_known;
    logic [7:0]  mb_echo, mb_inputs;
    logic [15:0] mb_reply;
    logic        smp_tick;
    logic [7:0]  rd_mux;

    mbox_hostregs #(.ADDR_W(ADDR_W)) u_host (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .arg(cmd_arg), .code(cmd_code),
        .spare(cmd_spare), .go(cmd_go)
    );

    mbox_dispatch #(.NPWM(NPWM)) u_disp (
        .clk(clk), .rst_n(rst_n), .go(cmd_go), .code(cmd_code),
        .arg(cmd_arg), .spare(cmd_spare), .known(cmd_known),
        .relay(relay_out), .echo(mb_echo), .reply(mb_reply)
    );

    mbox_insample #(.DIV(SAMPLE_DIV)) u_smp (
        .clk(clk), .rst_n(rst_n), .pins(iso_in),
        .sampled(mb_inputs), .tick(smp_tick)
    );

    // Select the byte at the addressed offset.
    always_comb begin
        case (bus_addr)
            A_OUT0:  rd_mux = cmd_arg[7:0];
            A_OUT1:  rd_mux = cmd_arg[15:8];
            A_OUT2:  rd_mux = cmd_code;
            A_OUT3:  rd_mux = cmd_spare;
            A_IN0:   rd_mux = mb_reply[7:0];
            A_IN1:   rd_mux = mb_reply[15:8];
            A_IN2:   rd_mux = mb_echo;
            A_IN3:   rd_mux = mb_inputs;
            default: rd_mux = 8'h00;
        endcase
    end

    // Register read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/mbox_responder_chk.sv
// Checker for the mailbox responder: temporal properties on the command
// path and on the input sampler. Bound into every mbox_responder.
module mbox_responder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        go,
    input logic [7:0]  code,
    input logic [15:0] arg,
    input logic        known,
    input logic [7:0]  relay_out,
    input logic [7:0]  echo,
    input logic [15:0] reply,
    input logic        tick,
    input logic [7:0]  sampled
);
    p_relay_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go && known && code == 8'h01) |=> relay_out == $past(arg[7:0]));

    p_relay_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(go && known && code == 8'h01) |=> $stable(relay_out));

    p_echo_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && known) |=> echo == $past(code));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> ($stable(echo) && $stable(reply)));

    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (go && known && code == 8'h00) |=> (echo == 8'h00 && reply == 16'h0000));

    p_unknown_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !known) |=> ($stable(echo) && $stable(reply)));

    p_sample_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sampled));
endmodule

bind mbox_responder mbox_responder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .go(cmd_go), .code(cmd_code), .arg(cmd_arg),
    .known(cmd_known), .relay_out(relay_out), .echo(mb_echo),
    .reply(mb_reply), .tick(smp_tick), .sampled(mb_inputs)
);

// File: tb/mbox_responder_test.sv
`timescale 1ns/1ps
module mbox_responder_test;
    localparam int DIV = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] iso_in = '0;
    logic [7:0] relay_out;

    int compared = 0, mismatched = 0, cyc = 0;
    string tag = "R1";

    mbox_responder #(.ADDR_W(6), .NPWM(2), .SAMPLE_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .iso_in(iso_in), .relay_out(relay_out)
    );

    always #4 clk = ~clk;

    // Behavioural reference state.
    int o_reg[4];
    int m_reply, m_echo, m_relay, m_ena, m_in, s1, s2, scnt, exp_rd;
    int m_hi[2], m_lo[2], m_bc[2];
    int pend, pend_code;

    function automatic int look(input int q);
        if (q == 1 || q == 2) return m_relay;
        if (q == 'h1F) return m_ena;
        if (q == 'h10) return m_hi[0];
        if (q == 'h11) return m_lo[0];
        if (q == 'h12) return m_hi[1];
        if (q == 'h13) return m_lo[1];
        if (q == 'h14) return m_bc[0];
        if (q == 'h15) return m_bc[1];
        return 0;
    endfunction

    task automatic run_cmd(input int c, input int p, input int sp);
        int ok = 1;
        int fb = 0;
        if (sp != 0) return;
        case (c)
            0: fb = 0;
            1: begin m_relay = p & 'hFF; fb = m_relay; end
            2: fb = m_relay;
            7: fb = look(p & 'hFF);
            'h1F: begin m_ena = p & 3; fb = m_ena; end
            'h10: begin m_hi[0] = p; fb = p; end
            'h11: begin m_lo[0] = p; fb = p; end
            'h12: begin m_hi[1] = p; fb = p; end
            'h13: begin m_lo[1] = p; fb = p; end
            'h14: begin m_bc[0] = p; fb = p; end
            'h15: begin m_bc[1] = p; fb = p; end
            default: ok = 0;
        endcase
        if (ok) begin m_reply = fb; m_echo = c; end
    endtask

    function automatic int rd_val(input int a);
        case (a)
            'h0C: return o_reg[0];
            'h0D: return o_reg[1];
            'h0E: return o_reg[2];
            'h0F: return o_reg[3];
            'h1C: return m_reply & 'hFF;
            'h1D: return (m_reply >> 8) & 'hFF;
            'h1E: return m_echo;
            'h1F: return m_in;
            default: return 0;
        endcase
    endfunction

    // Reference model step, in the same order as the hardware sees it.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (o_reg[i]) o_reg[i] = 0;
            for (int i = 0; i < 2; i++) begin m_hi[i] = 0; m_lo[i] = 0; m_bc[i] = 0; end
            m_reply = 0; m_echo = 0; m_relay = 0; m_ena = 0; m_in = 0;
            s1 = 0; s2 = 0; scnt = 0; exp_rd = 0; pend = 0; pend_code = 0;
        end else begin
            if (bus_rd) exp_rd = rd_val(int'(bus_addr));
            if (pend) run_cmd(pend_code, o_reg[0] | (o_reg[1] << 8), o_reg[3]);
            pend = 0;
            if (bus_wr && bus_addr >= 6'h0C && bus_addr <= 6'h0F)
                o_reg[int'(bus_addr) - 'h0C] = int'(bus_wdata);
            if (bus_wr && bus_addr == 6'h0E) begin pend = 1; pend_code = int'(bus_wdata); end
            if (scnt == DIV - 1) begin m_in = s2; scnt = 0; end
            else scnt++;
            s2 = s1;
            s1 = int'(iso_in);
        end
    end

    // Compare outputs against the model on every cycle.
    always @(negedge clk) begin
        compared++;
        if (int'(bus_rdata) != exp_rd) begin
            mismatched++;
            $display("FAIL %s: bus_rdata actual %02h expected %02h at cycle %0d",
                     tag, bus_rdata, exp_rd, cyc);
        end
        compared++;
        if (int'(relay_out) != m_relay) begin
            mismatched++;
            $display("FAIL %s: relay_out actual %02h expected %02h at cycle %0d",
                     tag, relay_out, m_relay, cyc);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected under 60000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic wr(input int a, input int d);
        bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a);
        bus_rd = 1'b1; bus_addr = 6'(a);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input int c, input int p);
        wr('h0C, p & 'hFF);
        wr('h0D, (p >> 8) & 'hFF);
        wr('h0E, c);
        rd('h1E);          // one cycle after: still the old echo
        rd('h1E);
        rd('h1C);
        rd('h1D);
    endtask

    initial begin
        int seed = 7;
        int codes[10] = '{1, 2, 7, 'h10, 'h11, 'h12, 'h13, 'h14, 'h15, 'h1F};
        tag = "R1";
        idle(5);
        rst_n = 1'b1;
        for (int a = 'h0C; a <= 'h0F; a++) rd(a);
        for (int a = 'h1C; a <= 'h1F; a++) rd(a);

        tag = "R2";
        wr('h0C, 'hA5); wr('h0D, 'h3C); wr('h0F, 0);
        rd('h0C); rd('h0D); rd('h0F);
        wr('h1C, 'hFF); wr('h1E, 'h77); rd('h1C); rd('h1E);
        rd('h00); rd('h3F); idle(2);

        tag = "R3";
        cmd(2, 0);
        tag = "R4";
        cmd(1, 'h005A); cmd(2, 'h1234); cmd(1, 'hFFC3);

        tag = "R5";
        cmd(2, 0); cmd(2, 0);   // repeat shows no visible change
        cmd(0, 'hBEEF);
        cmd(2, 0);

        tag = "R6";
        cmd('h10, 'h1234); cmd('h11, 'h0056); cmd('h12, 'hFFFF);
        cmd('h13, 'h0001); cmd('h14, 'h0007); cmd('h15, 'h8000);
        cmd('h1F, 'hFFFE);

        tag = "R7";
        for (int q = 'h10; q <= 'h15; q++) cmd(7, q);
        cmd(7, 'h1F); cmd(7, 'h01); cmd(7, 'h33); cmd(7, 'h07);

        tag = "R8";
        cmd('h55, 'h0011); cmd('h03, 'h0022);
        wr('h0F, 1);
        cmd(1, 'h00AA); cmd('h10, 'h4444);
        wr('h0F, 0);
        cmd(7, 'h10);

        tag = "R9";
        iso_in = 8'h5A; idle(25); rd('h1F); rd('h1F);
        iso_in = 8'hC3; idle(3); rd('h1F); idle(18); rd('h1F); rd('h1F);
        for (int k = 0; k < 30; k++) begin
            iso_in = 8'(k * 37);
            rd('h1F);
        end

        tag = "R3";
        for (int k = 0; k < 60; k++) begin
            seed = seed * 1103515245 + 12345;
            cmd(codes[(seed >>> 16) & 'h7FFF % 10 >= 0 ? ((seed >>> 16) & 'h7FFF) % 10 : 0],
                (seed >>> 8) & 'hFFFF);
        end

        idle(3);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule